// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two operands and a carry-in without any clock. The word is cut into slices of equal width, four bits each in the default configuration. A slice does not ripple a carry to the next slice. Inside the slice, per-bit generate (both operand bits set) and propagate (either operand bit set) terms feed a lookahead network. That network forms every carry inside the slice directly as a sum of products. The slice also forms a group generate and a group propagate pair, and it has no carry-out.

A second lookahead network, built from the same parameterized unit, takes the group pairs and the carry-in. From them it forms the carry into each upper slice and the final carry-out. The block works the same way for unsigned and two's-complement operands. Users choose the word width and the slice width through parameters. A configuration with a single slice leaves out the second level.

Top module: `cla_adder16`

## Requirements
- R1: `{carry_out, sum_out}` equals `opa + opb + carry_in` for every input combination at the default width of 16 bits, and outputs follow inputs with no clock.
- R2: When `carry_in` is 1 the result is exactly one greater than the result for the same operands with `carry_in` at 0, modulo 2^(WIDTH+1).
- R3: The carry entering slice k (bit position k*GROUP) equals bit k*GROUP of the sum of the operands' low k*GROUP bits plus `carry_in`, so a carry launched in slice 0 reaches every slice.
- R4: When `opb` is the bitwise complement of `opa`, every bit propagates: with `carry_in` = 0 the sum is all ones and `carry_out` is 0; with `carry_in` = 1 the sum is zero and `carry_out` is 1.
- R5: When both operand MSBs are 1, `carry_out` is 1; when both are 0, `carry_out` is 0, whatever the lower bits.
- R6: Adding a zero `opb` with `carry_in` = 0 returns `opa` unchanged with `carry_out` = 0.
- R7: Every configuration with WIDTH a multiple of GROUP and GROUP at least 2 obeys the R1 rule at its own width, including a 2-slice 8-bit build; other parameter values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH (16) | First addend |
| opb | input | WIDTH (16) | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH (16) | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the MSB |

## Verification
The bench sweeps every operand pair and carry-in of an 8-bit, two-slice build. In that build the second-level unit is in use, so a wrong term in a second-level carry equation shows up as a sum off by 2^4 or a wrong carry-out. At 16 bits it drives the long-propagate cases (all-ones against zero with carry-in, complement pairs, alternating bit patterns) and then random operands. A lookahead term that drops a propagate factor would either pass a carry through a blocking bit or lose one across three slices. The MSB generate and kill pairs expose a carry-out that comes from the wrong group pair.

// File: rtl/cla_pkg.sv
package cla_pkg;
   // smallest slice that still has an internal lookahead carry
   localparam int unsigned MIN_GROUP = 2;

   typedef struct packed {
      logic gen;
      logic prop;
   } grp_pair_t;
endpackage

// File: rtl/cla_lookahead.sv
// Parameterized lookahead unit: every carry is a flat sum of products.
module cla_lookahead #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] gen,
   input  logic [N-1:0] prop,
   input  logic         cin,
   output logic [N-1:1] carry,
   output logic         grp_g,
   output logic         grp_p
);
   generate
      if (N < cla_pkg::MIN_GROUP) begin : g_bad_n
         $error("cla_lookahead: N must be at least 2");
      end
   endgenerate

   always_comb begin
      logic acc;
      logic term;
      for (int k = 1; k < N; k++) begin
         acc = cin;
         for (int m = 0; m < k; m++) acc = acc & prop[m];
         for (int j = 0; j < k; j++) begin
            term = gen[j];
            for (int m = j + 1; m < k; m++) term = term & prop[m];
            acc = acc | term;
         end
         carry[k] = acc;
      end
   end

   always_comb begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < N; j++) begin
         term = gen[j];
         for (int m = j + 1; m < N; m++) term = term & prop[m];
         acc = acc | term;
      end
      grp_g = acc;
      grp_p = &prop;
   end
endmodule

// File: rtl/cla_slice.sv
// One slice: bit terms, internal lookahead carries, sum, group pair.
module cla_slice #(
   parameter int unsigned GROUP = 4
) (
   input  logic [GROUP-1:0]  a,
   input  logic [GROUP-1:0]  b,
   input  logic              cin,
   output logic [GROUP-1:0]  sum,
   output cla_pkg::grp_pair_t pair
);
   logic [GROUP-1:0] bit_g;
   logic [GROUP-1:0] bit_p;
   logic [GROUP-1:1] inner_c;
   logic [GROUP-1:0] c_vec;

   assign bit_g = a & b;
   assign bit_p = a | b;

   cla_lookahead #(.N(GROUP)) u_la (
      .gen   (bit_g),
      .prop  (bit_p),
      .cin   (cin),
      .carry (inner_c),
      .grp_g (pair.gen),
      .grp_p (pair.prop)
   );

   assign c_vec = {inner_c, cin};
   assign sum   = a ^ b ^ c_vec;
endmodule

// File: rtl/cla_adder16.sv
// Top: slices joined by a second-level lookahead unit.
module cla_adder16 #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned GROUP = 4
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             carry_out
);
   localparam int unsigned NG = WIDTH / GROUP;

   generate
      if (GROUP < cla_pkg::MIN_GROUP) begin : g_bad_group
         $error("cla_adder16: GROUP must be at least 2");
      end
      if ((WIDTH % GROUP) != 0 || WIDTH == 0) begin : g_bad_width
         $error("cla_adder16: WIDTH must be a nonzero multiple of GROUP");
      end
   endgenerate

   cla_pkg::grp_pair_t [NG-1:0] pairs;
   logic [NG-1:0]              pg_gen;
   logic [NG-1:0]              pg_prop;
   logic [NG:0]                grp_carry;

   assign grp_carry[0] = carry_in;

   generate
      for (genvar s = 0; s < NG; s++) begin : g_slice
         cla_slice #(.GROUP(GROUP)) u_slice (
            .a    (opa[s*GROUP +: GROUP]),
            .b    (opb[s*GROUP +: GROUP]),
            .cin  (grp_carry[s]),
            .sum  (sum_out[s*GROUP +: GROUP]),
            .pair (pairs[s])
         );
         assign pg_gen[s]  = pairs[s].gen;
         assign pg_prop[s] = pairs[s].prop;
      end

      if (NG == 1) begin : g_single
         assign grp_carry[1] = pg_gen[0] | (pg_prop[0] & carry_in);
      end else begin : g_two_level
         logic top_g;
         logic top_p;
         cla_lookahead #(.N(NG)) u_lvl2 (
            .gen   (pg_gen),
            .prop  (pg_prop),
            .cin   (carry_in),
            .carry (grp_carry[NG-1:1]),
            .grp_g (top_g),
            .grp_p (top_p)
         );
         assign grp_carry[NG] = top_g | (top_p & carry_in);
      end
   endgenerate

   assign carry_out = grp_carry[NG];
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned GROUP = 4
) (
   input logic [WIDTH-1:0]       opa,
   input logic [WIDTH-1:0]       opb,
   input logic                   carry_in,
   input logic [WIDTH-1:0]       sum_out,
   input logic                   carry_out,
   input logic [WIDTH/GROUP:0]   grp_carry
);
   localparam int unsigned NG = WIDTH / GROUP;

   always_comb begin
      logic [WIDTH:0] ref_sum;
      ref_sum = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};
      p_full_sum_r1: assert ({carry_out, sum_out} == ref_sum);
   end

   always_comb begin
      logic [WIDTH:0] mask;
      logic [WIDTH:0] low_sum;
      for (int k = 1; k < NG; k++) begin
         mask    = ({{WIDTH{1'b0}}, 1'b1} << (k * GROUP)) - 1'b1;
         low_sum = ({1'b0, opa} & mask) + ({1'b0, opb} & mask)
                   + {{WIDTH{1'b0}}, carry_in};
         p_slice_carry_r3: assert (grp_carry[k] == low_sum[k*GROUP]);
      end
   end

   always_comb begin
      if (opb == ~opa) begin
         p_prop_chain_r4: assert (sum_out == {WIDTH{~carry_in}} && carry_out == carry_in);
      end
   end

   always_comb begin
      if (opa[WIDTH-1] && opb[WIDTH-1]) begin
         p_msb_generate_r5: assert (carry_out);
      end
      if (!opa[WIDTH-1] && !opb[WIDTH-1]) begin
         p_msb_kill_r5: assert (!carry_out);
      end
   end

   always_comb begin
      if (opb == '0 && !carry_in) begin
         p_zero_ident_r6: assert (sum_out == opa && !carry_out);
      end
   end
endmodule

bind cla_adder16 cla_adder16_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (
   .opa       (opa),
   .opb       (opb),
   .carry_in  (carry_in),
   .sum_out   (sum_out),
   .carry_out (carry_out),
   .grp_carry (grp_carry)
);

// File: tb/tb_cla_adder16.sv
`timescale 1ns/1ps
module tb_cla_adder16;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [15:0] a16, b16, s16;
   logic        c16, co16;
   logic [7:0]  a8, b8, s8;
   logic        c8, co8;

   cla_adder16 dut (
      .opa(a16), .opb(b16), .carry_in(c16), .sum_out(s16), .carry_out(co16)
   );
   cla_adder16 #(.WIDTH(8), .GROUP(4)) dut_w8 (
      .opa(a8), .opb(b8), .carry_in(c8), .sum_out(s8), .carry_out(co8)
   );

   task automatic chk16(input logic [15:0] a, input logic [15:0] b,
                        input logic c, input string tag);
      logic [16:0] exp;
      a16 = a; b16 = b; c16 = c;
      #1;
      exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
      checks++;
      if ({co16, s16} !== exp) begin
         errors++;
         $display("FAIL %s: a=%h b=%h c=%b got %h expected %h",
                  tag, a, b, c, {co16, s16}, exp);
      end
   endtask

   task automatic chk_cout(input logic [15:0] a, input logic [15:0] b,
                           input logic c, input logic exp_co, input string tag);
      a16 = a; b16 = b; c16 = c;
      #1;
      checks++;
      if (co16 !== exp_co) begin
         errors++;
         $display("FAIL %s: a=%h b=%h c=%b carry got %b expected %b",
                  tag, a, b, c, co16, exp_co);
      end
   endtask

   task automatic chk_step(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] r0;
      logic [16:0] r1;
      a16 = a; b16 = b; c16 = 1'b0;
      #1 r0 = {co16, s16};
      c16 = 1'b1;
      #1 r1 = {co16, s16};
      checks++;
      if (r1 !== r0 + 17'd1) begin
         errors++;
         $display("FAIL R2: a=%h b=%h got %h expected %h", a, b, r1, r0 + 17'd1);
      end
   endtask

   initial begin
      a16 = '0; b16 = '0; c16 = 1'b0;
      a8  = '0; b8  = '0; c8  = 1'b0;
      #2;
      // initial state with all inputs at zero (R1)
      checks++;
      if ({co16, s16} !== 17'd0) begin
         errors++;
         $display("FAIL R1: zero inputs got %h expected 0", {co16, s16});
      end

      // R3: carry launched in slice 0 crosses all slices
      chk16(16'hFFFF, 16'h0000, 1'b1, "R3");
      chk16(16'h0FFF, 16'h0001, 1'b0, "R3");
      chk16(16'h00FF, 16'h0001, 1'b0, "R3");
      chk16(16'h000F, 16'h0001, 1'b0, "R3");
      chk16(16'h0FFF, 16'h0000, 1'b1, "R3");
      // R4: complement pairs, every bit propagates
      chk16(16'hAAAA, 16'h5555, 1'b0, "R4");
      chk16(16'hAAAA, 16'h5555, 1'b1, "R4");
      chk16(16'h0000, 16'hFFFF, 1'b1, "R4");
      chk16(16'h3C3C, 16'hC3C3, 1'b1, "R4");
      // R1 alternating and all-ones patterns
      chk16(16'hFFFF, 16'hFFFF, 1'b1, "R1");
      chk16(16'hFFFF, 16'hFFFF, 1'b0, "R1");
      chk16(16'hAAAA, 16'hAAAA, 1'b1, "R1");
      chk16(16'h5555, 16'h5555, 1'b0, "R1");
      // R5: MSB generate and kill
      chk_cout(16'h8000, 16'h8000, 1'b0, 1'b1, "R5");
      chk_cout(16'h8000, 16'h8000, 1'b1, 1'b1, "R5");
      chk_cout(16'h7FFF, 16'h7FFF, 1'b1, 1'b0, "R5");
      chk_cout(16'h7FFF, 16'h0001, 1'b1, 1'b0, "R5");
      // R6: zero identity
      chk16(16'h1234, 16'h0000, 1'b0, "R6");
      chk16(16'hFFFF, 16'h0000, 1'b0, "R6");
      // R2: carry-in adds one
      chk_step(16'hFFFF, 16'h0000);
      chk_step(16'h1234, 16'h4321);
      chk_step(16'h7FFF, 16'h8000);
      for (int i = 0; i < 200; i++) chk_step(16'($urandom), 16'($urandom));

      // R1: random vectors
      for (int i = 0; i < 10000; i++)
         chk16(16'($urandom), 16'($urandom), 1'($urandom), "R1");

      // R7: exhaustive two-slice 8-bit build
      for (int v = 0; v < (1 << 17); v++) begin
         logic [8:0] exp8;
         a8 = v[7:0]; b8 = v[15:8]; c8 = v[16];
         #1;
         exp8 = {1'b0, a8} + {1'b0, b8} + {8'd0, c8};
         checks++;
         if ({co8, s8} !== exp8) begin
            errors++;
            $display("FAIL R7: a=%h b=%h c=%b got %h expected %h",
                     a8, b8, c8, {co8, s8}, exp8);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int cyc = 0; cyc < 150000; cyc++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule